// File: doc/BRIEF.md
# Memory BIST Subtest Sequencer

This block runs one memory self-test subtest over a range of addresses. A 16-bit control word is captured when a start pulse is accepted. Its operation field picks a short list of memory commands (two or three reads and writes), and the sequencer issues that list at every address of the chosen range before it moves to the next address. The range can be walked upward or downward. The bounds come from one of four low/high address pairs, which are presented as packed banks and selected by a field of the control word.

Each command goes out on a request/acknowledge port. The address, the write enable and the data are held steady until the memory acknowledges the command. The data of each command is a fixed pattern, or that pattern bitwise inverted, according to complement bits in the control word. Read data returns with the acknowledge and is compared against the data expected for that command. A miscompare sets a sticky error flag. The block drives a single-cycle done pulse when the subtest ends. A control word that the block cannot run ends the subtest at once with a configuration-error flag set.

Top module: `mbist_subtest_seq`

## Requirements
- R1: The operation field `ctrl_word[3:0]` selects the command list issued at each address. The codes are 4'b0011 for write, read; 4'b0100 for read, write, read; 4'b1000 for read, read, write; and 4'b0101 for read, write, write. `mem_we` is 1 for a write.
- R2: All commands for one address are acknowledged before the address changes. `ctrl_word[7]`=0 walks from the low bound up to the high bound, and 1 walks from the high bound down to the low bound. The number of acknowledged commands is therefore (high-low+1) times the length of the list.
- R3: Each command's data is PATTERN or ~PATTERN. It is inverted when the XOR of three terms is 1: `ctrl_word[4]` if the command is a write, `ctrl_word[5]` if it is the second command of the list, and `ctrl_word[6]` if it is the third.
- R4: A read whose `mem_rdata` differs from its expected data (R3) sets `data_err`. The flag holds until the next accepted start, which clears it.
- R5: `ctrl_word[15:14]` = i selects the bounds `range_lo_bank[i*AW +: AW]` and `range_hi_bank[i*AW +: AW]`, with low <= high.
- R6: A start is refused when the operation code is not one of those in R1, when `ctrl_word[8]` (random addressing) is 1, or when `ctrl_word[11:9]` (data mode) is not 000. A refused start issues no command, sets `cfg_err` and pulses `done` in the next cycle. `cfg_err` clears on the next start that is not refused.
- R7: A `start` pulse while `busy` is 1 is ignored. The running subtest keeps the control word and the range it captured.
- R8: `done` is high for exactly one cycle, in the cycle after the last command at the final address is acknowledged. `busy` falls in that same cycle.
- R9: After reset no request is made and `busy`, `done`, `data_err` and `cfg_err` are 0. While `mem_req` is 1 and `mem_ack` is 0, the request fields do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle start pulse |
| ctrl_word | input | 16 | Subtest control word, captured at start |
| range_lo_bank | input | 4*AW | Four packed low address bounds |
| range_hi_bank | input | 4*AW | Four packed high address bounds |
| mem_req | output | 1 | Command request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Command address |
| mem_wdata | output | DW | Write data (expected data on reads) |
| mem_ack | input | 1 | Command accepted; read data valid |
| mem_rdata | input | DW | Read data, valid with mem_ack |
| busy | output | 1 | Subtest running |
| done | output | 1 | One-cycle end-of-subtest pulse |
| data_err | output | 1 | Sticky read miscompare flag |
| cfg_err | output | 1 | Control word was refused |

## Verification
The bench goes after the boundaries of the address walk: a single-address range, and a downward walk that must start at the high bound. A design that got either wrong would skip an address, repeat one, or run past the bound. The bench holds off the acknowledge for some cycles, so a design that moved its address on a partial list or let the request drift would issue commands out of order. It also injects a miscompare, restarts after an error, sends each kind of refused control word, and pulses start in the middle of a run. These cases expose an error flag that is lost or never cleared, a refused word that still reaches memory, and a second start that corrupts the running subtest.

// File: rtl/mbist_pkg.sv
// Shared constants and types for the memory BIST subtest sequencer.
// Assumes a 16-bit control word; field positions are fixed here.
package mbist_pkg;
    localparam int NUM_RANGES = 4;
    localparam int RSEL_W     = $clog2(NUM_RANGES);
    localparam int MAX_SLOTS  = 3;
    localparam int SLOT_W     = $clog2(MAX_SLOTS);

    localparam logic [3:0] OP_WR  = 4'b0011;
    localparam logic [3:0] OP_RWR = 4'b0100;
    localparam logic [3:0] OP_RRW = 4'b1000;
    localparam logic [3:0] OP_RWW = 4'b0101;

    localparam int CW_INV_WR  = 4;
    localparam int CW_INV_2ND = 5;
    localparam int CW_INV_3RD = 6;
    localparam int CW_REVERSE = 7;
    localparam int CW_RANDOM  = 8;
    localparam int CW_DMODE   = 9;
    localparam int CW_RSEL    = 14;

    // Decoded command list: index of last slot and per-slot write flag.
    typedef struct packed {
        logic                 valid;
        logic [SLOT_W-1:0]    last_slot;
        logic [MAX_SLOTS-1:0] is_write;
    } seq_t;
endpackage

// File: rtl/mbist_op_decode.sv
// Operation decoder: turns the operation code into a command list and
// flags control words the sequencer cannot run. Purely combinational.
module mbist_op_decode
    import mbist_pkg::*;
(
    input  logic [3:0] op,
    input  logic       random_mode,
    input  logic [2:0] data_mode,
    output seq_t       seq
);
    // Map each supported code to its list; others stay invalid.
    always_comb begin
        logic known;
        seq   = '0;
        known = 1'b1;
        case (op)
            OP_WR:  begin seq.last_slot = SLOT_W'(1); seq.is_write = 3'b001; end
            OP_RWR: begin seq.last_slot = SLOT_W'(2); seq.is_write = 3'b010; end
            OP_RRW: begin seq.last_slot = SLOT_W'(2); seq.is_write = 3'b100; end
            OP_RWW: begin seq.last_slot = SLOT_W'(2); seq.is_write = 3'b110; end
            default: known = 1'b0;
        endcase
        seq.valid = known && !random_mode && (data_mode == 3'b000);
    end
endmodule

// File: rtl/mbist_slot_data.sv
// Per-slot data generator: each slot carries the fixed pattern or its
// inverse. Inversion is the XOR of the write-invert bit (writes only) and
// the per-position invert bit of the second and third slots.
module mbist_slot_data
    import mbist_pkg::*;
#(
    parameter int              DW      = 16,
    parameter logic [DW-1:0]   PATTERN = 16'hA5C3
) (
    input  logic                          inv_wr,
    input  logic                          inv_2nd,
    input  logic                          inv_3rd,
    input  logic [MAX_SLOTS-1:0]          is_write,
    output logic [MAX_SLOTS-1:0][DW-1:0]  slot_data
);
    for (genvar k = 0; k < MAX_SLOTS; k++) begin : g_slot
        logic flip;
        if (k == 1) begin : g_second
            assign flip = (inv_wr & is_write[k]) ^ inv_2nd;
        end else if (k == 2) begin : g_third
            assign flip = (inv_wr & is_write[k]) ^ inv_3rd;
        end else begin : g_first
            assign flip = inv_wr & is_write[k];
        end
        // Select the pattern or its bitwise inverse for this slot.
        assign slot_data[k] = flip ? ~PATTERN : PATTERN;
    end
endmodule

// File: rtl/mbist_addr_walker.sv
// Address walker: loads a first and last address and steps by one toward
// the last address. Assumes the range was loaded in walk order.
module mbist_addr_walker #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] first,
    input  logic [AW-1:0] last,
    input  logic          reverse,
    input  logic          advance,
    output logic [AW-1:0] addr,
    output logic          at_last
);
    logic [AW-1:0] addr_q, last_q;
    logic          rev_q;

    // Hold the current address and step it once per finished address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            last_q <= '0;
            rev_q  <= 1'b0;
        end else if (load) begin
            addr_q <= first;
            last_q <= last;
            rev_q  <= reverse;
        end else if (advance) begin
            addr_q <= rev_q ? addr_q - AW'(1) : addr_q + AW'(1);
        end
    end

    assign addr    = addr_q;
    assign at_last = (addr_q == last_q);
endmodule

// File: rtl/mbist_subtest_seq.sv
// Memory BIST subtest sequencer top. Captures a control word on start,
// issues the decoded command list at every address of the selected range
// and compares read data on acknowledge. Assumes the memory holds a
// request until it acknowledges it and returns read data with the ack.
module mbist_subtest_seq
    import mbist_pkg::*;
#(
    parameter int            AW      = 6,
    parameter int            DW      = 16,
    parameter logic [DW-1:0] PATTERN = 16'hA5C3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [15:0]              ctrl_word,
    input  logic [NUM_RANGES*AW-1:0] range_lo_bank,
    input  logic [NUM_RANGES*AW-1:0] range_hi_bank,
    output logic                     mem_req,
    output logic                     mem_we,
    output logic [AW-1:0]            mem_addr,
    output logic [DW-1:0]            mem_wdata,
    input  logic                     mem_ack,
    input  logic [DW-1:0]            mem_rdata,
    output logic                     busy,
    output logic                     done,
    output logic                     data_err,
    output logic                     cfg_err
);
    typedef enum logic {ST_IDLE, ST_RUN} state_e;

    state_e                         state_q;
    logic [11:0]                    cw_q;
    logic [SLOT_W-1:0]              slot_q;
    logic                           done_q, derr_q, cerr_q;
    logic [11:0]                    dec_cw;
    seq_t                           seq;
    logic [RSEL_W-1:0]              rsel;
    logic [AW-1:0]                  lo, hi, first, last;
    logic                           accept, launch, reject;
    logic                           hit, slot_end, advance, finish;
    logic                           at_last;
    logic [MAX_SLOTS-1:0][DW-1:0]   slot_data;
    logic                           cur_we;
    logic [DW-1:0]                  cur_data;
    logic                           unused_cw;

    assign unused_cw = ^{ctrl_word[13:12], cw_q[CW_REVERSE]};

    // Decode the live word when idle (for refusal), the captured one when running.
    assign dec_cw = (state_q == ST_RUN) ? cw_q : ctrl_word[11:0];

    mbist_op_decode u_dec (
        .op          (dec_cw[3:0]),
        .random_mode (dec_cw[CW_RANDOM]),
        .data_mode   (dec_cw[CW_DMODE +: 3]),
        .seq         (seq)
    );

    // Pick the bound pair and order it by walk direction.
    assign rsel  = ctrl_word[CW_RSEL +: RSEL_W];
    assign lo    = range_lo_bank[rsel*AW +: AW];
    assign hi    = range_hi_bank[rsel*AW +: AW];
    assign first = ctrl_word[CW_REVERSE] ? hi : lo;
    assign last  = ctrl_word[CW_REVERSE] ? lo : hi;

    assign accept   = (state_q == ST_IDLE) && start;
    assign launch   = accept && seq.valid;
    assign reject   = accept && !seq.valid;
    assign hit      = mem_req && mem_ack;
    assign slot_end = hit && (slot_q == seq.last_slot);
    assign advance  = slot_end && !at_last;
    assign finish   = slot_end && at_last;

    mbist_addr_walker #(.AW(AW)) u_walk (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (launch),
        .first   (first),
        .last    (last),
        .reverse (ctrl_word[CW_REVERSE]),
        .advance (advance),
        .addr    (mem_addr),
        .at_last (at_last)
    );

    mbist_slot_data #(.DW(DW), .PATTERN(PATTERN)) u_data (
        .inv_wr    (cw_q[CW_INV_WR]),
        .inv_2nd   (cw_q[CW_INV_2ND]),
        .inv_3rd   (cw_q[CW_INV_3RD]),
        .is_write  (seq.is_write),
        .slot_data (slot_data)
    );

    assign cur_we   = seq.is_write[slot_q];
    assign cur_data = slot_data[slot_q];

    // Control state: capture on start, step slots on ack, finish at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cw_q    <= '0;
            slot_q  <= '0;
            done_q  <= 1'b0;
            derr_q  <= 1'b0;
            cerr_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                derr_q <= 1'b0;
                cw_q   <= ctrl_word[11:0];
                slot_q <= '0;
                cerr_q <= reject;
                done_q <= reject;
                if (launch) state_q <= ST_RUN;
            end
            if (hit && !cur_we && (mem_rdata != cur_data)) derr_q <= 1'b1;
            if (hit) slot_q <= slot_end ? '0 : slot_q + SLOT_W'(1);
            if (finish) begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
            end
        end
    end

    assign mem_req   = (state_q == ST_RUN);
    assign mem_we    = cur_we;
    assign mem_wdata = cur_data;
    assign busy      = (state_q == ST_RUN);
    assign done      = done_q;
    assign data_err  = derr_q;
    assign cfg_err   = cerr_q;
endmodule

// File: rtl/mbist_subtest_seq_chk.sv
// Protocol checker for the subtest sequencer, bound to every instance.
// Observes ports only; keeps one address of history for the step check.
module mbist_subtest_seq_chk #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          mem_ack,
    input logic          busy,
    input logic          done,
    input logic          data_err,
    input logic          cfg_err
);
    logic [AW-1:0] prev_addr, up_addr, dn_addr;

    // Remember last cycle's address for the step check.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_addr <= '0;
        else        prev_addr <= mem_addr;
    end
    assign up_addr = prev_addr + AW'(1);
    assign dn_addr = prev_addr - AW'(1);

    // R9: an unacknowledged request holds its fields.
    a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R2: after an ack the address stays or moves by exactly one.
    a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> (!mem_req || mem_addr == prev_addr || mem_addr == up_addr || mem_addr == dn_addr));

    // R4: the miscompare flag cannot clear while a subtest runs.
    a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && data_err) |=> data_err);

    // R6: a refused word never leaves the block running.
    a_r6_cfg_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!busy && !mem_req));

    // R7: start cannot end or restart a run; only an ack can.
    a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_ack) |=> busy);

    // R8: done coincides with idle and lasts one cycle unless restarted.
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !mem_req));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done);
endmodule

bind mbist_subtest_seq mbist_subtest_seq_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .busy      (busy),
    .done      (done),
    .data_err  (data_err),
    .cfg_err   (cfg_err)
);

// File: tb/tb_mbist_subtest_seq.sv
// Bench: behavioural reference (command queue plus flag model) compared
// with the design on every falling edge; memory model answers requests.
module tb_mbist_subtest_seq;
    localparam int            AW  = 6;
    localparam int            DW  = 16;
    localparam logic [DW-1:0] PAT = 16'hA5C3;
    localparam int            NR  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [15:0]       ctrl_word = '0;
    logic [NR*AW-1:0]  range_lo_bank, range_hi_bank;
    logic              mem_req, mem_we, mem_ack = 1'b0;
    logic [AW-1:0]     mem_addr;
    logic [DW-1:0]     mem_wdata, mem_rdata = '0;
    logic              busy, done, data_err, cfg_err;

    mbist_subtest_seq #(.AW(AW), .DW(DW), .PATTERN(PAT)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ctrl_word(ctrl_word),
        .range_lo_bank(range_lo_bank), .range_hi_bank(range_hi_bank),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .data_err(data_err), .cfg_err(cfg_err)
    );

    always #2 clk = ~clk;

    typedef struct packed {
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } cmd_t;

    cmd_t          q[$];
    logic [DW-1:0] mem [0:(1<<AW)-1];
    logic          m_busy = 0, m_done = 0, m_derr = 0, m_cerr = 0;
    int            n_acks = 0;
    int            checks = 0, fails = 0;
    int            cyc = 0;
    logic          inj_en = 0;
    logic [AW-1:0] inj_addr = '0;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, got, exp, cyc);
        end
    endtask

    function automatic bit word_ok(input logic [15:0] cw);
        bit op_ok;
        op_ok = (cw[3:0] == 4'b0011) || (cw[3:0] == 4'b0100) ||
                (cw[3:0] == 4'b1000) || (cw[3:0] == 4'b0101);
        return op_ok && !cw[8] && (cw[11:9] == 3'b000);
    endfunction

    // Build the full expected command stream for one accepted word.
    task automatic build_queue(input logic [15:0] cw);
        int  n;
        bit  wr [3];
        int  sel, lo, hi, a;
        case (cw[3:0])
            4'b0011: begin n = 2; wr[0] = 1; wr[1] = 0; wr[2] = 0; end
            4'b0100: begin n = 3; wr[0] = 0; wr[1] = 1; wr[2] = 0; end
            4'b1000: begin n = 3; wr[0] = 0; wr[1] = 0; wr[2] = 1; end
            default: begin n = 3; wr[0] = 0; wr[1] = 1; wr[2] = 1; end
        endcase
        sel = int'(cw[15:14]);
        lo  = int'(range_lo_bank[sel*AW +: AW]);
        hi  = int'(range_hi_bank[sel*AW +: AW]);
        for (int i = 0; i <= hi - lo; i++) begin
            a = cw[7] ? hi - i : lo + i;
            for (int k = 0; k < n; k++) begin
                cmd_t c;
                bit   inv;
                inv = wr[k] && cw[4];
                if (k == 1) inv = inv ^ cw[5];
                if (k == 2) inv = inv ^ cw[6];
                c.we   = wr[k];
                c.addr = AW'(a);
                c.data = inv ? ~PAT : PAT;
                q.push_back(c);
            end
        end
    endtask

    // Reference model: advances on the bench's own ack and start stimulus.
    always @(posedge clk) begin
        bit was;
        cmd_t c;
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_derr = 0; m_cerr = 0;
            q.delete();
        end else begin
            was    = m_busy;
            m_done = 0;
            if (was && mem_ack && q.size() > 0) begin
                c = q.pop_front();
                n_acks++;
                if (c.we) mem[c.addr] = c.data;
                else if (mem_rdata != c.data) m_derr = 1;
                if (q.size() == 0) begin m_busy = 0; m_done = 1; end
            end
            if (!was && start) begin
                m_derr = 0;
                if (!word_ok(ctrl_word)) begin
                    m_cerr = 1; m_done = 1;
                end else begin
                    m_cerr = 0; m_busy = 1;
                    build_queue(ctrl_word);
                end
            end
        end
    end

    // Falling edge: compare against the model, then answer the memory port.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            check("R7 R8 busy", busy, m_busy);
            check("R8 done", done, m_done);
            check("R4 data_err", data_err, m_derr);
            check("R6 cfg_err", cfg_err, m_cerr);
            check("R9 mem_req", mem_req, m_busy && q.size() > 0);
            if (m_busy && q.size() > 0) begin
                check("R1 command kind", mem_we, q[0].we);
                check("R2 R5 command address", mem_addr, q[0].addr);
                if (q[0].we) check("R3 write data", mem_wdata, q[0].data);
            end
        end
        mem_ack   <= mem_req && (cyc % 3 != 2);
        mem_rdata <= mem[mem_addr] ^ ((inj_en && mem_addr == inj_addr) ? DW'(1) : DW'(0));
    end

    // Run one subtest and check its end-of-run results.
    task automatic run(input logic [15:0] cw, input int exp_cmds, input logic exp_derr,
                       input logic exp_cerr, input bit disturb, input string tag);
        int waitc;
        bit seen;
        n_acks = 0;
        @(negedge clk);
        ctrl_word = cw;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        waitc = 0;
        seen  = 0;
        while (!seen && waitc < 3000) begin
            if (done) seen = 1;
            else begin
                if (disturb && waitc == 3) begin start = 1'b1; ctrl_word = 16'h0001; end
                else if (disturb && waitc == 4) start = 1'b0;
                @(negedge clk);
                waitc++;
            end
        end
        check({"R8 done seen ", tag}, seen, 1);
        check({"R2 command count ", tag}, n_acks, exp_cmds);
        check({"R4 final data_err ", tag}, data_err, exp_derr);
        check({"R6 final cfg_err ", tag}, cfg_err, exp_cerr);
        check({"R8 busy low at done ", tag}, busy, 0);
        @(negedge clk);
        check({"R8 done single cycle ", tag}, done, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < (1 << AW); i++) mem[i] = PAT;
        range_lo_bank = {AW'(30), AW'(20), AW'(10), AW'(2)};
        range_hi_bank = {AW'(33), AW'(20), AW'(13), AW'(5)};
        repeat (3) @(negedge clk);
        check("R9 reset mem_req", mem_req, 0);
        check("R9 reset busy", busy, 0);
        check("R9 reset done", done, 0);
        check("R9 reset flags", {data_err, cfg_err}, 0);
        rst_n = 1'b1;

        run(16'h0003, 8, 0, 0, 0, "R1 write-read up, pair 0");
        run(16'h40D4, 12, 0, 0, 0, "R3 read-write-read down, pair 1");
        run(16'h4008, 12, 1, 0, 0, "R4 read-read-write miscompare");
        run(16'hC025, 12, 0, 0, 1, "R7 read-write-write, start mid-run");
        inj_en = 1; inj_addr = AW'(20);
        run(16'h8003, 2, 1, 0, 0, "R5 single address injected error");
        inj_en = 0;
        run(16'h0001, 0, 0, 1, 0, "R6 unknown code");
        run(16'h0103, 0, 0, 1, 0, "R6 random mode");
        run(16'h0203, 0, 0, 1, 0, "R6 data mode");
        run(16'h0083, 8, 0, 0, 0, "R2 write-read down after refusal");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule